// File: doc/BRIEF.md
# Two-Edge Compare Pulse Generator

This block drives one output pin with a pulse whose leading and trailing edges come from two independent equality comparators that watch a shared counter bus. Comparator A places the leading edge and comparator B the trailing edge. Each comparator is one-shot. Software writes a value into the comparator's staging register, and that value is copied into the live compare register once output-disable is low. The copy arms the comparator. When the counter bus equals the live value, the comparator fires once and then disarms itself.

A polarity input sets the level the pin takes on an A match, and a B match drives the inverse level. A flag input selects whether the event flag is raised on both matches or only on the trailing (B) match. The flag is cleared by a write-one-to-clear strobe. Pulses keep coming for as long as software keeps re-arming the comparators, whatever the state of the flag.

A mode-enable input says whether the channel is running in this mode. While it is low, both comparators are held disarmed and staging writes are dropped, but the pin keeps its level. On entry to the mode, the pin therefore holds its previous value until the first match.

Each comparator is a three-state machine:
- `CMP_IDLE`: disarmed.
- `CMP_PEND`: a staged value is waiting for output-disable to go low.
- `CMP_ARMED`: the live value is being compared against the bus.

Transitions:
- IDLE→PEND on a staging write.
- PEND→PEND on a further write, or while output-disable is high.
- PEND→ARMED when output-disable is low and no write arrives.
- ARMED→IDLE on a match.
- ARMED→PEND on a new staging write.
- Any state→IDLE while mode-enable is low.

Top module: `dual_edge_compare`

## Requirements
- R1: After reset, `pulse_out` and `event_flag` are 0 and both comparators are disarmed.
- R2: A staged value reaches the live compare register and arms the comparator only on a clock edge where `out_disable` is 0. While `out_disable` is 1, a counter value equal to the staged value has no effect on `pulse_out` or `event_flag`.
- R3: When the armed comparator A sees `count_bus` equal to its live value at a clock edge, `pulse_out` becomes `edge_pol` one clock edge later.
- R4: When the armed comparator B sees `count_bus` equal to its live value at a clock edge, `pulse_out` becomes the inverse of `edge_pol` one clock edge later.
- R5: Each comparator fires at most once per arming. A later return of `count_bus` to the same value changes nothing.
- R6: With `flag_on_both` = 0, an A match leaves `event_flag` unchanged and a B match sets it.
- R7: With `flag_on_both` = 1, both an A match and a B match set `event_flag`.
- R8: If both comparators match on the same edge, `pulse_out` takes the B level, the inverse of `edge_pol`.
- R9: A high `flag_clear` clears `event_flag` on the next edge. A flag set on that same edge wins over the clear.
- R10: While `mode_en` is 0, both comparators are disarmed, staging writes are ignored and `pulse_out` holds its level. After `mode_en` returns to 1, no match happens until a new staging write arms a comparator.
- R11: With `event_flag` still set, newly armed compares keep moving `pulse_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_en | input | 1 | High while the channel runs in this mode |
| count_bus | input | CNT_W | Selected counter bus value |
| stage_a_we | input | 1 | Write strobe for the staging register of comparator A |
| stage_a_data | input | CNT_W | Data for the staging register of comparator A |
| stage_b_we | input | 1 | Write strobe for the staging register of comparator B |
| stage_b_data | input | CNT_W | Data for the staging register of comparator B |
| out_disable | input | 1 | High blocks the staged-to-live transfer |
| edge_pol | input | 1 | Pin level driven on an A match; B drives its inverse |
| flag_on_both | input | 1 | 1: flag on both matches; 0: flag on the B match only |
| flag_clear | input | 1 | Write-one-to-clear strobe for the flag |
| pulse_out | output | 1 | Output pin |
| event_flag | output | 1 | Match event flag |

## Verification
Events follow a fixed schedule:
- A staging write is captured on the first edge and copied to the live register on the second.
- From the third edge on, the bus is compared against the live value.
- A bus value presented at a compare edge registers the hit on that edge.
- The pin and the flag change on the following edge, two edges after the value appeared.

The bench changes every input at the falling edge and counts rising edges inside each scenario task to match this schedule. It reads outputs only at the falling edge after the edge where they are due. In cases where a match must be absent, it holds the same sampling point, so a late change cannot slip past the check.

// File: rtl/dec_pkg.sv
package dec_pkg;

    typedef enum logic [1:0] {
        CMP_IDLE  = 2'd0,
        CMP_PEND  = 2'd1,
        CMP_ARMED = 2'd2
    } cmp_state_t;

    localparam int unsigned CMP_COUNT = 2;
    localparam int unsigned CMP_LEAD  = 0;
    localparam int unsigned CMP_TRAIL = 1;

endpackage

// File: rtl/dec_comparator.sv
module dec_comparator
    import dec_pkg::*;
#(
    parameter int unsigned CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_en,
    input  logic             out_disable,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [CNT_W-1:0] count_bus,
    output logic             hit_q
);

    cmp_state_t       state_q, state_d;
    logic [CNT_W-1:0] stage_q;
    logic [CNT_W-1:0] live_q;
    logic             load_now;
    logic             match_now;

    assign load_now  = mode_en && (state_q == CMP_PEND) && !wr_en && !out_disable;
    assign match_now = mode_en && (state_q == CMP_ARMED) && !wr_en && (count_bus == live_q);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CMP_IDLE: begin
                if (wr_en) state_d = CMP_PEND;
            end
            CMP_PEND: begin
                if (wr_en)             state_d = CMP_PEND;
                else if (!out_disable) state_d = CMP_ARMED;
            end
            CMP_ARMED: begin
                if (wr_en)                    state_d = CMP_PEND;
                else if (count_bus == live_q) state_d = CMP_IDLE;
            end
            default: state_d = CMP_IDLE;
        endcase
        if (!mode_en) state_d = CMP_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CMP_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
            live_q  <= '0;
            hit_q   <= 1'b0;
        end else begin
            if (wr_en && mode_en) stage_q <= wr_data;
            if (load_now)         live_q  <= stage_q;
            hit_q <= match_now;
        end
    end

    assert_hold_while_disabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CMP_PEND && out_disable && mode_en) |=> (state_q == CMP_PEND));

    assert_one_shot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CMP_ARMED && mode_en && !wr_en && count_bus == live_q)
            |=> (hit_q && state_q != CMP_ARMED));

    assert_no_hit_unarmed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != CMP_ARMED) |=> !hit_q);

    assert_mode_exit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_en |=> (state_q == CMP_IDLE && !hit_q));

endmodule

// File: rtl/dec_output.sv
module dec_output (
    input  logic clk,
    input  logic rst_n,
    input  logic hit_lead,
    input  logic hit_trail,
    input  logic edge_pol,
    input  logic flag_on_both,
    input  logic flag_clear,
    output logic pulse_out,
    output logic event_flag
);

    logic flag_set;

    assign flag_set = hit_trail || (flag_on_both && hit_lead);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pulse_out  <= 1'b0;
            event_flag <= 1'b0;
        end else begin
            if (hit_trail)     pulse_out <= ~edge_pol;
            else if (hit_lead) pulse_out <= edge_pol;
            if (flag_set)        event_flag <= 1'b1;
            else if (flag_clear) event_flag <= 1'b0;
        end
    end

    assert_lead_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_lead && !hit_trail) |=> (pulse_out == $past(edge_pol)));

    assert_trail_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hit_trail |=> (pulse_out == !$past(edge_pol)));

    assert_trail_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hit_trail |=> event_flag);

    assert_lead_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!event_flag && hit_lead && !hit_trail && !flag_on_both) |=> !event_flag);

    assert_hold_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit_lead && !hit_trail) |=> $stable(pulse_out));

endmodule

// File: rtl/dual_edge_compare.sv
module dual_edge_compare
    import dec_pkg::*;
#(
    parameter int unsigned CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_en,
    input  logic [CNT_W-1:0] count_bus,
    input  logic             stage_a_we,
    input  logic [CNT_W-1:0] stage_a_data,
    input  logic             stage_b_we,
    input  logic [CNT_W-1:0] stage_b_data,
    input  logic             out_disable,
    input  logic             edge_pol,
    input  logic             flag_on_both,
    input  logic             flag_clear,
    output logic             pulse_out,
    output logic             event_flag
);

    logic             wr_vec   [CMP_COUNT];
    logic [CNT_W-1:0] data_vec [CMP_COUNT];
    logic             hit_vec  [CMP_COUNT];

    assign wr_vec[CMP_LEAD]    = stage_a_we;
    assign wr_vec[CMP_TRAIL]   = stage_b_we;
    assign data_vec[CMP_LEAD]  = stage_a_data;
    assign data_vec[CMP_TRAIL] = stage_b_data;

    for (genvar gi = 0; gi < CMP_COUNT; gi++) begin : g_cmp
        dec_comparator #(
            .CNT_W(CNT_W)
        ) u_cmp (
            .clk        (clk),
            .rst_n      (rst_n),
            .mode_en    (mode_en),
            .out_disable(out_disable),
            .wr_en      (wr_vec[gi]),
            .wr_data    (data_vec[gi]),
            .count_bus  (count_bus),
            .hit_q      (hit_vec[gi])
        );
    end

    dec_output u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .hit_lead    (hit_vec[CMP_LEAD]),
        .hit_trail   (hit_vec[CMP_TRAIL]),
        .edge_pol    (edge_pol),
        .flag_on_both(flag_on_both),
        .flag_clear  (flag_clear),
        .pulse_out   (pulse_out),
        .event_flag  (event_flag)
    );

endmodule

// File: tb/dual_edge_compare_tb.sv
module dual_edge_compare_tb;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 24;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             mode_en = 1'b1;
    logic [CNT_W-1:0] count_bus = '0;
    logic             stage_a_we = 1'b0;
    logic [CNT_W-1:0] stage_a_data = '0;
    logic             stage_b_we = 1'b0;
    logic [CNT_W-1:0] stage_b_data = '0;
    logic             out_disable = 1'b0;
    logic             edge_pol = 1'b1;
    logic             flag_on_both = 1'b0;
    logic             flag_clear = 1'b0;
    logic             pulse_out;
    logic             event_flag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_edge_compare #(.CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .mode_en(mode_en), .count_bus(count_bus),
        .stage_a_we(stage_a_we), .stage_a_data(stage_a_data),
        .stage_b_we(stage_b_we), .stage_b_data(stage_b_data),
        .out_disable(out_disable), .edge_pol(edge_pol),
        .flag_on_both(flag_on_both), .flag_clear(flag_clear),
        .pulse_out(pulse_out), .event_flag(event_flag)
    );

    task automatic check(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // staging write captured on edge 1, transferred to the live register on edge 2
    task automatic write_a(input logic [CNT_W-1:0] v);
        stage_a_we = 1'b1; stage_a_data = v;
        tick();
        stage_a_we = 1'b0;
        tick();
    endtask

    task automatic write_b(input logic [CNT_W-1:0] v);
        stage_b_we = 1'b1; stage_b_data = v;
        tick();
        stage_b_we = 1'b0;
        tick();
    endtask

    // value seen at one edge, outputs due one edge later
    task automatic present(input logic [CNT_W-1:0] v);
        count_bus = v;
        tick();
        count_bus = '0;
        tick();
    endtask

    task automatic clear_flag();
        flag_clear = 1'b1;
        tick();
        flag_clear = 1'b0;
    endtask

    task automatic t_reset();
        check("R1", "pulse_out after reset", pulse_out, 1'b0);
        check("R1", "event_flag after reset", event_flag, 1'b0);
        present(24'd0);
        check("R1", "no match while disarmed", pulse_out, 1'b0);
    endtask

    task automatic t_basic_pulse();
        edge_pol = 1'b1; flag_on_both = 1'b0;
        write_a(24'd100);
        write_b(24'd200);
        present(24'd100);
        check("R3", "lead edge level", pulse_out, 1'b1);
        check("R6", "no flag on lead match", event_flag, 1'b0);
        present(24'd200);
        check("R4", "trail edge level", pulse_out, 1'b0);
        check("R6", "flag on trail match", event_flag, 1'b1);
        clear_flag();
        check("R9", "flag cleared", event_flag, 1'b0);
    endtask

    task automatic t_one_shot();
        present(24'd100);
        check("R5", "lead does not refire", pulse_out, 1'b0);
        check("R5", "no flag from spent compare", event_flag, 1'b0);
    endtask

    task automatic t_flag_both();
        edge_pol = 1'b0; flag_on_both = 1'b1;
        write_a(24'd300);
        write_b(24'd400);
        present(24'd300);
        check("R7", "lead level with pol 0", pulse_out, 1'b0);
        check("R7", "flag on lead match", event_flag, 1'b1);
        clear_flag();
        present(24'd400);
        check("R7", "trail level with pol 0", pulse_out, 1'b1);
        check("R7", "flag on trail match", event_flag, 1'b1);
        clear_flag();
    endtask

    task automatic t_out_disable();
        out_disable = 1'b1;
        write_a(24'd500);
        present(24'd500);
        check("R2", "no match while transfer blocked", pulse_out, 1'b1);
        check("R2", "no flag while transfer blocked", event_flag, 1'b0);
        out_disable = 1'b0;
        tick();
        present(24'd500);
        check("R2", "match after transfer unblocked", pulse_out, 1'b0);
        clear_flag();
    endtask

    task automatic t_simultaneous();
        edge_pol = 1'b1; flag_on_both = 1'b0;
        write_a(24'd700);
        present(24'd700);
        check("R3", "lead sets high before tie", pulse_out, 1'b1);
        write_a(24'd600);
        write_b(24'd600);
        present(24'd600);
        check("R8", "trail level wins tie", pulse_out, 1'b0);
        clear_flag();
    endtask

    task automatic t_set_priority();
        flag_on_both = 1'b1;
        write_a(24'd800);
        count_bus = 24'd800;
        tick();
        count_bus = '0;
        flag_clear = 1'b1;
        tick();
        flag_clear = 1'b0;
        check("R9", "set wins over clear", event_flag, 1'b1);
        clear_flag();
        check("R9", "clear alone", event_flag, 1'b0);
    endtask

    task automatic t_mode_exit();
        // pin is high from previous lead match
        mode_en = 1'b0;
        write_b(24'd900);
        present(24'd900);
        check("R10", "pin holds with mode off", pulse_out, 1'b1);
        mode_en = 1'b1;
        tick();
        present(24'd900);
        check("R10", "no match after mode entry", pulse_out, 1'b1);
        check("R10", "no flag after mode entry", event_flag, 1'b0);
    endtask

    task automatic t_continue();
        edge_pol = 1'b1; flag_on_both = 1'b0;
        write_b(24'd1000);
        present(24'd1000);
        check("R11", "flag set, pin low", event_flag, 1'b1);
        write_a(24'd1100);
        write_b(24'd1200);
        present(24'd1100);
        check("R11", "lead with flag set", pulse_out, 1'b1);
        present(24'd1200);
        check("R11", "trail with flag set", pulse_out, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic_pulse();
        t_one_shot();
        t_flag_both();
        t_out_disable();
        t_simultaneous();
        t_set_priority();
        t_mode_exit();
        t_continue();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule